// File: doc/BRIEF.md
# LCD Line-Latch Pulse Timing Generator

This block produces the horizontal latch strobe that a TFT column driver uses to take in one row of pixel data. It runs entirely from the system clock. The strobe is placed inside each line by a fixed lead of 15 system clocks plus a programmable setup delay counted in groups of eight clocks. Its length is also programmable in groups of eight clocks. When the length field is zero, the strobe instead follows the valid-data window reported by the pixel path. An alternate mode stretches that window until the next pixel-clock enable.

The block also makes a line-rate clock for the gate driver, with a period of (period field + 1) × 16 system clocks. It keeps repeating that period on its own until the next line-start strobe restarts it. A frame-start strobe resets a line index. A flag marks the run of dummy gate clocks that comes before the first valid row. That run starts at line index (frame count − common count − dummy count), saturating at zero, and lasts for the dummy count in lines.

Line settings are captured at each line-start strobe. Frame settings are captured at each frame-start strobe. Between strobes, changes on the configuration inputs have no effect.

Top module: `llp_timing_gen`

## Requirements
- R1: After reset, llp_o, lcp1_o and dummy_o are 0, and llp_o and lcp1_o stay 0 until the first line_start.
- R2: Counting the clock edge that samples line_start as cycle 0, lcp1_o is high in cycles 0 to P/2−1 and low in cycles P/2 to P−1, where P = (cfg_period + 1) × 16.
- R3: With a nonzero cfg_width, llp_o rises in cycle A = 15 + 8 × cfg_setup. With cfg_setup = 0, this gives cycle 15.
- R4: With a nonzero cfg_width, llp_o stays high for 8 × cfg_width cycles. The pulse is cut short at the end of the line period (cycle P−1 is its last high cycle).
- R5: When 15 + 8 × cfg_setup ≥ P, the rise point is clamped to cycle P−1.
- R6: With cfg_width = 0 and cfg_alt_mode = 0, llp_o equals data_valid delayed by one clock.
- R7: With cfg_width = 0 and cfg_alt_mode = 1, llp_o stays high after data_valid falls. It remains high up to and including the cycle in which the first pix_ce is sampled.
- R8: Line settings are captured only on line_start. Changes on the configuration inputs in mid-line do not affect the current period, nor any repeated period, until the next line_start.
- R9: Without a new line_start, the line period repeats every P cycles, with the same llp_o and lcp1_o pattern.
- R10: frame_start sets the line index to 0; each later line_start increments it. dummy_o is high while the index lies in [L, L + cfg_dummy), where L = max(0, cfg_frame − cfg_common − cfg_dummy) and the frame settings are captured at frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe that starts a line and captures the line settings |
| frame_start | input | 1 | One-cycle strobe that resets the line index and captures the frame settings |
| data_valid | input | 1 | Valid pixel-data window from the data path |
| pix_ce | input | 1 | Pixel-clock enable, one cycle per pixel period |
| cfg_setup | input | 5 | Setup delay in units of 8 system clocks, added to the fixed lead of 15 |
| cfg_width | input | 8 | Strobe width in units of 8 system clocks; 0 selects the follow-data mode |
| cfg_alt_mode | input | 1 | Extends the follow-data strobe to the next pix_ce |
| cfg_period | input | 8 | Line period field; period = (value + 1) × 16 clocks |
| cfg_dummy | input | 3 | Number of dummy gate-clock lines |
| cfg_frame | input | 10 | Frame length in lines |
| cfg_common | input | 10 | Common-line count |
| llp_o | output | 1 | Registered line-latch strobe |
| lcp1_o | output | 1 | Registered line-rate clock, high in the first half of each period |
| dummy_o | output | 1 | Registered flag for the dummy gate-clock lines |

## Verification
A wrong value in the line counter or in the captured settings shows up within one line period. It moves the lcp1_o half-period boundary, or it moves the llp_o rise or fall cycle away from 15 + 8 × setup and its width. The bench measures both of these at cycle resolution. A stale or wrongly captured setting is exposed when the configuration changes in mid-line: the current period then shows the new timing instead of the old one. A slip in the line index or in the lead computation moves the dummy_o window by whole lines. This is seen on the line_start where the window should open or close.

// File: rtl/llp_timing_pkg.sv
package llp_timing_pkg;

    localparam int SETUP_W   = 5;
    localparam int PULSE_W   = 8;
    localparam int PERIOD_W  = 8;
    localparam int DUMMY_W   = 3;
    localparam int FRAME_W   = 10;
    localparam int SLOT_LOG2 = 4;   // 16 clocks per period step
    localparam int UNIT_LOG2 = 3;   // 8 clocks per setup/width unit
    localparam int FIXED_LEAD = 15; // fixed lead in front of the setup delay
    localparam int CNT_W     = PERIOD_W + SLOT_LOG2 + 1;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic [SETUP_W-1:0]  setup;
        logic [PULSE_W-1:0]  width;
        logic                alt;
        logic [PERIOD_W-1:0] period;
    } line_cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [FRAME_W-1:0] common;
        logic [DUMMY_W-1:0] dummy;
    } frame_cfg_t;

    function automatic cnt_t line_len(input line_cfg_t c);
        return (cnt_t'(c.period) + cnt_t'(1)) << SLOT_LOG2;
    endfunction

    function automatic cnt_t assert_point(input line_cfg_t c);
        cnt_t raw;
        cnt_t len;
        raw = cnt_t'(FIXED_LEAD) + (cnt_t'(c.setup) << UNIT_LOG2);
        len = line_len(c);
        return (raw >= len) ? (len - cnt_t'(1)) : raw;
    endfunction

    function automatic cnt_t pulse_end(input line_cfg_t c, input cnt_t start);
        cnt_t wide;
        cnt_t len;
        wide = start + (cnt_t'(c.width) << UNIT_LOG2);
        len  = line_len(c);
        return (wide > len) ? len : wide;
    endfunction

    function automatic logic [FRAME_W-1:0] lead_lines(input frame_cfg_t f);
        logic [FRAME_W:0] sum;
        logic [FRAME_W:0] tot;
        sum = {1'b0, f.common} + (FRAME_W+1)'(f.dummy);
        tot = {1'b0, f.frame};
        return (tot > sum) ? FRAME_W'(tot - sum) : '0;
    endfunction

endpackage

// File: rtl/llp_line_timer.sv
module llp_line_timer
    import llp_timing_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line_start,
    input  line_cfg_t cfg_in,
    output logic      run_q,
    output logic      run_nxt,
    output cnt_t      cnt_q,
    output cnt_t      cnt_nxt,
    output line_cfg_t sh_q,
    output line_cfg_t sh_nxt,
    output logic      lcp1_o
);

    logic lcp1_q;

    always_comb begin
        sh_nxt  = line_start ? cfg_in : sh_q;
        run_nxt = run_q | line_start;
        if (line_start || !run_q) begin
            cnt_nxt = '0;
        end else if (cnt_q == line_len(sh_q) - cnt_t'(1)) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt_q + cnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            run_q  <= 1'b0;
            cnt_q  <= '0;
            lcp1_q <= 1'b0;
        end else begin
            sh_q   <= sh_nxt;
            run_q  <= run_nxt;
            cnt_q  <= cnt_nxt;
            lcp1_q <= run_nxt && (cnt_nxt < (line_len(sh_nxt) >> 1));
        end
    end

    assign lcp1_o = lcp1_q;

    // R2: the line clock rises only when the period counter restarts
    p_lcp1_rise_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(lcp1_q) |-> (cnt_q == '0));

    // R9: the counter never leaves the programmed period
    p_cnt_in_period_r9: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q < line_len(sh_q)));

endmodule

// File: rtl/llp_pulse_gen.sv
module llp_pulse_gen
    import llp_timing_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line_start,
    input  logic      run_q,
    input  logic      run_nxt,
    input  cnt_t      cnt_q,
    input  cnt_t      cnt_nxt,
    input  line_cfg_t sh_q,
    input  line_cfg_t sh_nxt,
    input  logic      data_valid,
    input  logic      pix_ce,
    output logic      llp_o
);

    cnt_t rise_at;
    cnt_t fall_at;
    logic in_window;
    logic follow;
    logic llp_nxt;
    logic llp_q;
    logic ext_q;

    always_comb begin
        rise_at   = assert_point(sh_nxt);
        fall_at   = pulse_end(sh_nxt, rise_at);
        in_window = (cnt_nxt >= rise_at) && (cnt_nxt < fall_at);
        follow    = data_valid | (sh_nxt.alt & ext_q);
        llp_nxt   = run_nxt && ((sh_nxt.width == '0) ? follow : in_window);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            llp_q <= 1'b0;
            ext_q <= 1'b0;
        end else begin
            llp_q <= llp_nxt;
            if (data_valid) begin
                ext_q <= 1'b1;
            end else if (pix_ce) begin
                ext_q <= 1'b0;
            end
        end
    end

    assign llp_o = llp_q;

    // R3: a programmed pulse starts exactly at the (clamped) setup point
    p_rise_point_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(llp_q) && sh_q.width != '0) |-> (cnt_q == assert_point(sh_q)));

    // R4: a programmed pulse ends after its width or at the period wrap
    p_fall_point_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(llp_q) && sh_q.width != '0 && !$past(line_start)) |->
        (cnt_q == ((pulse_end(sh_q, assert_point(sh_q)) == line_len(sh_q))
                   ? cnt_t'(0) : pulse_end(sh_q, assert_point(sh_q)))));

    // R6: in follow mode without extension the strobe is the delayed window
    p_follow_window_r6: assert property (@(posedge clk) disable iff (rst)
        (run_q && sh_q.width == '0 && !sh_q.alt) |-> (llp_q == $past(data_valid)));

endmodule

// File: rtl/llp_dummy_track.sv
module llp_dummy_track
    import llp_timing_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       line_start,
    input  frame_cfg_t fcfg_in,
    output logic       dummy_o
);

    frame_cfg_t          fsh_q;
    frame_cfg_t          fsh_nxt;
    logic                framed_q;
    logic                framed_nxt;
    logic [FRAME_W-1:0]  idx_q;
    logic [FRAME_W-1:0]  idx_nxt;
    logic [FRAME_W-1:0]  lead;
    logic [FRAME_W:0]    stop;
    logic                dummy_nxt;
    logic                dummy_q;

    always_comb begin
        fsh_nxt    = frame_start ? fcfg_in : fsh_q;
        framed_nxt = framed_q | frame_start;
        if (frame_start) begin
            idx_nxt = '0;
        end else if (line_start && idx_q != '1) begin
            idx_nxt = idx_q + FRAME_W'(1);
        end else begin
            idx_nxt = idx_q;
        end
        lead      = lead_lines(fsh_nxt);
        stop      = {1'b0, lead} + (FRAME_W+1)'(fsh_nxt.dummy);
        dummy_nxt = framed_nxt && (idx_nxt >= lead) && ({1'b0, idx_nxt} < stop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsh_q    <= '0;
            framed_q <= 1'b0;
            idx_q    <= '0;
            dummy_q  <= 1'b0;
        end else begin
            fsh_q    <= fsh_nxt;
            framed_q <= framed_nxt;
            idx_q    <= idx_nxt;
            dummy_q  <= dummy_nxt;
        end
    end

    assign dummy_o = dummy_q;

    // R10: the dummy window opens only on a line or frame boundary
    p_dummy_open_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(dummy_q) |-> $past(line_start || frame_start));

    // R10: and closes only on a line or frame boundary
    p_dummy_close_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(dummy_q) |-> $past(line_start || frame_start));

endmodule

// File: rtl/llp_timing_gen.sv
module llp_timing_gen
    import llp_timing_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                line_start,
    input  logic                frame_start,
    input  logic                data_valid,
    input  logic                pix_ce,
    input  logic [SETUP_W-1:0]  cfg_setup,
    input  logic [PULSE_W-1:0]  cfg_width,
    input  logic                cfg_alt_mode,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [DUMMY_W-1:0]  cfg_dummy,
    input  logic [FRAME_W-1:0]  cfg_frame,
    input  logic [FRAME_W-1:0]  cfg_common,
    output logic                llp_o,
    output logic                lcp1_o,
    output logic                dummy_o
);

    line_cfg_t  lcfg;
    frame_cfg_t fcfg;
    line_cfg_t  sh_q;
    line_cfg_t  sh_nxt;
    cnt_t       cnt_q;
    cnt_t       cnt_nxt;
    logic       run_q;
    logic       run_nxt;

    always_comb begin
        lcfg.setup  = cfg_setup;
        lcfg.width  = cfg_width;
        lcfg.alt    = cfg_alt_mode;
        lcfg.period = cfg_period;
        fcfg.frame  = cfg_frame;
        fcfg.common = cfg_common;
        fcfg.dummy  = cfg_dummy;
    end

    llp_line_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .cfg_in     (lcfg),
        .run_q      (run_q),
        .run_nxt    (run_nxt),
        .cnt_q      (cnt_q),
        .cnt_nxt    (cnt_nxt),
        .sh_q       (sh_q),
        .sh_nxt     (sh_nxt),
        .lcp1_o     (lcp1_o)
    );

    llp_pulse_gen u_pulse (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .run_q      (run_q),
        .run_nxt    (run_nxt),
        .cnt_q      (cnt_q),
        .cnt_nxt    (cnt_nxt),
        .sh_q       (sh_q),
        .sh_nxt     (sh_nxt),
        .data_valid (data_valid),
        .pix_ce     (pix_ce),
        .llp_o      (llp_o)
    );

    llp_dummy_track u_dummy (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .line_start  (line_start),
        .fcfg_in     (fcfg),
        .dummy_o     (dummy_o)
    );

    // R1: nothing toggles on the line outputs before the first line start
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (!llp_o && !lcp1_o));

endmodule

// File: tb/llp_timing_gen_tb.sv
module llp_timing_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_start = 1'b0;
    logic       frame_start = 1'b0;
    logic       data_valid = 1'b0;
    logic       pix_ce = 1'b0;
    logic [4:0] cfg_setup = '0;
    logic [7:0] cfg_width = '0;
    logic       cfg_alt_mode = 1'b0;
    logic [7:0] cfg_period = '0;
    logic [2:0] cfg_dummy = '0;
    logic [9:0] cfg_frame = '0;
    logic [9:0] cfg_common = '0;
    logic       llp_o;
    logic       lcp1_o;
    logic       dummy_o;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    llp_timing_gen u_dut (
        .clk          (clk),
        .rst          (rst),
        .line_start   (line_start),
        .frame_start  (frame_start),
        .data_valid   (data_valid),
        .pix_ce       (pix_ce),
        .cfg_setup    (cfg_setup),
        .cfg_width    (cfg_width),
        .cfg_alt_mode (cfg_alt_mode),
        .cfg_period   (cfg_period),
        .cfg_dummy    (cfg_dummy),
        .cfg_frame    (cfg_frame),
        .cfg_common   (cfg_common),
        .llp_o        (llp_o),
        .lcp1_o       (lcp1_o),
        .dummy_o      (dummy_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_line(input int s, input int w, input int p, input bit alt);
        cfg_setup    = 5'(s);
        cfg_width    = 8'(w);
        cfg_period   = 8'(p);
        cfg_alt_mode = alt;
    endtask

    // leaves the bench at the falling edge after the capturing edge (cycle 0)
    task automatic pulse_line();
        @(negedge clk) line_start = 1'b1;
        @(negedge clk) line_start = 1'b0;
    endtask

    // watch one period of len cycles, starting at cycle 0 of that period
    task automatic observe(input bit start, input int len, input int exp_rise,
                           input int exp_high, input string req);
        int rise = -1;
        int highs = 0;
        int lcp_highs = 0;
        bit lcp_shape = 1'b1;
        bit prev = 1'b0;
        if (start) pulse_line();
        for (int k = 0; k < len; k++) begin
            if (llp_o && !prev && rise < 0) rise = k;
            if (llp_o) highs++;
            if (lcp1_o) lcp_highs++;
            if (lcp1_o != (k < len/2)) lcp_shape = 1'b0;
            prev = llp_o;
            @(negedge clk);
        end
        check(rise == exp_rise, {req, " llp rise cycle"}, rise, exp_rise);
        check(highs == exp_high, {req, " llp high cycles"}, highs, exp_high);
        check(lcp_shape && lcp_highs == len/2, {req, " R2 lcp1 half period"}, lcp_highs, len/2);
    endtask

    task automatic t_reset();
        check(!llp_o && !lcp1_o && !dummy_o, "R1 reset state", int'({llp_o, lcp1_o, dummy_o}), 0);
        set_line(0, 3, 0, 1'b0);
        data_valid = 1'b1;
        repeat (20) @(negedge clk);
        check(!llp_o && !lcp1_o, "R1 quiet before first line", int'({llp_o, lcp1_o}), 0);
        data_valid = 1'b0;
    endtask

    task automatic t_short_line();
        // P=16, A=15, width 16 clocks truncated to 1 cycle
        set_line(0, 2, 0, 1'b0);
        observe(1'b1, 16, 15, 1, "R3 R4 short line");
    endtask

    task automatic t_long_line();
        // P=128, A=15+24=39, width 32
        set_line(3, 4, 7, 1'b0);
        observe(1'b1, 128, 39, 32, "R3 R4 long line");
        observe(1'b0, 128, 39, 32, "R9 repeated period");
    endtask

    task automatic t_clamp();
        // P=32, raw 263 clamped to 31, width truncated to 1
        set_line(31, 1, 1, 1'b0);
        observe(1'b1, 32, 31, 1, "R5 clamp");
    endtask

    task automatic t_capture();
        // P=64, A=23, width 16; changes in mid-line must wait for next start
        set_line(1, 2, 3, 1'b0);
        pulse_line();
        set_line(0, 1, 3, 1'b0);
        observe(1'b0, 64, 23, 16, "R8 mid-line change ignored");
        observe(1'b0, 64, 23, 16, "R8 wrap keeps old settings");
        observe(1'b1, 64, 15, 8, "R8 new settings at line start");
    endtask

    task automatic t_follow(input bit alt, input int exp_high, input string req);
        int highs = 0;
        set_line(0, 0, 7, alt);
        pulse_line();
        repeat (3) @(negedge clk);
        for (int k = 0; k < 12; k++) begin
            data_valid = (k < 4);
            pix_ce     = (k == 6);
            @(negedge clk);
            if (llp_o) highs++;
            if (k == 0) check(llp_o == 1'b1, {req, " one-cycle delay"}, int'(llp_o), 1);
        end
        data_valid = 1'b0;
        pix_ce     = 1'b0;
        check(highs == exp_high, {req, " high cycles"}, highs, exp_high);
    endtask

    task automatic t_dummy_a();
        // lead = 10-4-3 = 3; active for line index 3,4,5
        cfg_frame = 10'd10; cfg_common = 10'd4; cfg_dummy = 3'd3;
        @(negedge clk) begin frame_start = 1'b1; line_start = 1'b1; end
        @(negedge clk) begin frame_start = 1'b0; line_start = 1'b0; end
        cfg_frame = 10'd0;
        check(dummy_o == 1'b0, "R10 index 0 idle", int'(dummy_o), 0);
        for (int k = 1; k <= 7; k++) begin
            pulse_line();
            check(dummy_o == (k >= 3 && k < 6), "R10 dummy window lead 3",
                  int'(dummy_o), int'(k >= 3 && k < 6));
        end
    endtask

    task automatic t_dummy_b();
        // 5 < 4+3: lead saturates at 0, active for index 0,1,2
        cfg_frame = 10'd5; cfg_common = 10'd4; cfg_dummy = 3'd3;
        @(negedge clk) begin frame_start = 1'b1; line_start = 1'b1; end
        @(negedge clk) begin frame_start = 1'b0; line_start = 1'b0; end
        check(dummy_o == 1'b1, "R10 saturated lead index 0", int'(dummy_o), 1);
        for (int k = 1; k <= 3; k++) begin
            pulse_line();
            check(dummy_o == (k < 3), "R10 saturated lead window",
                  int'(dummy_o), int'(k < 3));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_short_line();
        t_long_line();
        t_clamp();
        t_capture();
        t_follow(1'b0, 4, "R6 follow data window");
        t_follow(1'b1, 7, "R7 extended to pixel enable");
        t_dummy_a();
        t_dummy_b();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule